// File: doc/BRIEF.md
# 8-bit ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator machine. Each cycle it takes an operation code, a register operand and a memory operand. It returns the 8-bit result, a write enable for the result, and the condition flags that the operation produces. Operand fetch and address generation happen upstream. The block only evaluates one operation at a time and keeps the machine's flag file.

The flag file holds five bits: half carry H, interrupt mask I, negative N, zero Z and carry C. The operations read these flags from the flag file itself, not from an input. Each operation has its own rule for which flags it changes and which it keeps. The flag file takes the new values on a rising clock edge when `op_valid` is high.

The operation port is a stream input with a valid strobe and no ready signal. The block evaluates every operation in the same cycle, so it never applies back-pressure. An operation is consumed on every clock edge where `op_valid` is high. The result side has no ready signal either: `result_we` marks a result that the datapath must store.

Top module: `alu8_core`

## Requirements
- R1: `op_code` encoding is: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 AND, 6 OR, 7 XOR, 8 bit test, 9 load, 10 store, 11 negate, 12 complement, 13 logical shift right, 14 arithmetic shift right, 15 rotate right, 16 rotate left, 17 shift left, 18 increment, 19 decrement, 20 test, 21 clear, 22 set C, 23 clear C, 24 set I, 25 clear I. `result_we` is high only when `op_valid` is high and the operation writes its result; compare, bit test, test and the four flag operations never write.
- R2: Add gives `acc_in + mem_in`, and add-with-carry adds one more when C is 1. C is set when the true sum exceeds 255. H is set when bit 3 is 1 in both operands, or is 1 in either operand while bit 3 of the result is 0. No other operation changes H.
- R3: Subtract and compare give `acc_in - mem_in`, and subtract-with-carry takes one more when C is 1. Negate gives `0 - mem_in`. For all four, C is set when the true result is below zero, and the result is the low 8 bits.
- R4: AND, OR, XOR, bit test (the AND value, not written), load (returns `mem_in`) and store (returns `acc_in`) change only N and Z.
- R5: Complement returns the bitwise inverse of `mem_in` and always sets C to 1.
- R6: The right shifts move bit 0 of `mem_in` into C. Logical shift right fills bit 7 with 0. Arithmetic shift right keeps the original bit 7. Rotate right fills bit 7 with the old C.
- R7: The left shifts move bit 7 into C. Shift left fills bit 0 with 0, and rotate left fills bit 0 with the old C.
- R8: Increment and decrement wrap between 255 and 0 and leave C unchanged.
- R9: Clear returns 0 and leaves C unchanged. Test returns `mem_in` without writing it and updates only N and Z.
- R10: Set C, clear C, set I and clear I change only their own flag. I changes under no other operation.
- R11: For every operation from 0 to 21, the next N equals bit 7 of `result` and the next Z is 1 exactly when `result` is 0.
- R12: `flags` is {H,I,N,Z,C} on bits 4 to 0. Reset gives 5'b01000. A clock edge with `op_valid` high loads `flags_next`. A clock edge with `op_valid` low keeps the flags.
- R13: Codes 26 to 31 return 0, never write, and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation select |
| acc_in | input | 8 | Accumulator or index operand |
| mem_in | input | 8 | Memory operand |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result must be stored |
| flags_next | output | 5 | Flag values this operation produces |
| flags | output | 5 | Registered flag file {H,I,N,Z,C} |

## Verification
The only state in this block is the flag file, so any wrong internal state appears on `flags` one edge after the bad update. Every later carry-dependent operation also uses the wrong flag value. That error reaches `result` and `flags_next` in the same cycle the next carry-in operation is presented. The directed sequences chain operations so that each flag set by one step is consumed or checked by the next. A stray update to H, I or C is therefore caught within one or two operations. The idle cycles test that nothing is loaded when `op_valid` is low.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_SUB   = 5'd2,
    OP_SBC   = 5'd3,
    OP_CMP   = 5'd4,
    OP_AND   = 5'd5,
    OP_OR    = 5'd6,
    OP_XOR   = 5'd7,
    OP_BIT   = 5'd8,
    OP_LOAD  = 5'd9,
    OP_STORE = 5'd10,
    OP_NEG   = 5'd11,
    OP_COM   = 5'd12,
    OP_LSR   = 5'd13,
    OP_ASR   = 5'd14,
    OP_ROR   = 5'd15,
    OP_ROL   = 5'd16,
    OP_LSL   = 5'd17,
    OP_INC   = 5'd18,
    OP_DEC   = 5'd19,
    OP_TST   = 5'd20,
    OP_CLR   = 5'd21,
    OP_SETC  = 5'd22,
    OP_CLRC  = 5'd23,
    OP_SETI  = 5'd24,
    OP_CLRI  = 5'd25
  } alu_op_e;

  typedef struct packed {
    logic h;
    logic i;
    logic n;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RST = '{h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         do_sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         half
);
  localparam int HB = W / 2 - 1;

  logic [W:0] ext;

  always_comb begin
    if (do_sub)
      ext = {1'b0, lhs} - {1'b0, rhs} - {{W{1'b0}}, cin};
    else
      ext = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
  end

  assign sum   = ext[W-1:0];
  assign carry = ext[W];
  assign half  = (lhs[HB] & rhs[HB]) | (rhs[HB] & ~ext[HB]) | (lhs[HB] & ~ext[HB]);

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] d,
  input  logic         cin,
  output logic [W-1:0] q,
  output logic         cout
);
  always_comb begin
    case (op)
      OP_LSR: begin q = {1'b0, d[W-1:1]};   cout = d[0];   end
      OP_ASR: begin q = {d[W-1], d[W-1:1]}; cout = d[0];   end
      OP_ROR: begin q = {cin, d[W-1:1]};    cout = d[0];   end
      OP_ROL: begin q = {d[W-2:0], cin};    cout = d[W-1]; end
      OP_LSL: begin q = {d[W-2:0], 1'b0};   cout = d[W-1]; end
      default: begin q = d;                 cout = cin;    end
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  output logic [W-1:0] q
);
  always_comb begin
    case (op)
      OP_AND, OP_BIT: q = a & m;
      OP_OR:          q = a | m;
      OP_XOR:         q = a ^ m;
      OP_LOAD,
      OP_TST:         q = m;
      OP_STORE:       q = a;
      OP_COM:         q = ~m;
      OP_INC:         q = m + W'(1);
      OP_DEC:         q = m - W'(1);
      default:        q = '0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mem_in,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [4:0]        flags_next,
  output logic [4:0]        flags
);
  alu_op_e            op;
  flags_t             flags_q;
  flags_t             nx;
  logic [DATA_W-1:0]  as_lhs;
  logic               as_sub;
  logic               as_cin;
  logic [DATA_W-1:0]  as_sum;
  logic               as_carry;
  logic               as_half;
  logic [DATA_W-1:0]  sh_q;
  logic               sh_c;
  logic [DATA_W-1:0]  lg_q;
  logic [DATA_W-1:0]  res;
  logic               wr;
  logic               nz;

  assign op = alu_op_e'(op_code);

  // adder/subtractor steering
  always_comb begin
    as_lhs = acc_in;
    as_sub = 1'b1;
    as_cin = 1'b0;
    case (op)
      OP_ADD: as_sub = 1'b0;
      OP_ADC: begin as_sub = 1'b0; as_cin = flags_q.c; end
      OP_SBC: as_cin = flags_q.c;
      OP_NEG: as_lhs = '0;
      default: ;
    endcase
  end

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .lhs    (as_lhs),
    .rhs    (mem_in),
    .do_sub (as_sub),
    .cin    (as_cin),
    .sum    (as_sum),
    .carry  (as_carry),
    .half   (as_half)
  );

  alu8_shift #(.W(DATA_W)) u_shift (
    .op   (op),
    .d    (mem_in),
    .cin  (flags_q.c),
    .q    (sh_q),
    .cout (sh_c)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op (op),
    .a  (acc_in),
    .m  (mem_in),
    .q  (lg_q)
  );

  // per-operation result selection and flag rules
  always_comb begin
    res = '0;
    wr  = 1'b0;
    nz  = 1'b0;
    nx  = flags_q;
    case (op)
      OP_ADD, OP_ADC: begin
        res = as_sum; wr = 1'b1; nz = 1'b1; nx.c = as_carry; nx.h = as_half;
      end
      OP_SUB, OP_SBC, OP_NEG: begin
        res = as_sum; wr = 1'b1; nz = 1'b1; nx.c = as_carry;
      end
      OP_CMP: begin
        res = as_sum; nz = 1'b1; nx.c = as_carry;
      end
      OP_AND, OP_OR, OP_XOR, OP_LOAD, OP_STORE, OP_INC, OP_DEC, OP_CLR: begin
        res = lg_q; wr = 1'b1; nz = 1'b1;
      end
      OP_BIT, OP_TST: begin
        res = lg_q; nz = 1'b1;
      end
      OP_COM: begin
        res = lg_q; wr = 1'b1; nz = 1'b1; nx.c = 1'b1;
      end
      OP_LSR, OP_ASR, OP_ROR, OP_ROL, OP_LSL: begin
        res = sh_q; wr = 1'b1; nz = 1'b1; nx.c = sh_c;
      end
      OP_SETC: nx.c = 1'b1;
      OP_CLRC: nx.c = 1'b0;
      OP_SETI: nx.i = 1'b1;
      OP_CLRI: nx.i = 1'b0;
      default: ;
    endcase
    if (nz) begin
      nx.n = res[DATA_W-1];
      nx.z = ~|res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flags_q <= FLAGS_RST;
    else if (op_valid)
      flags_q <= nx;
  end

  assign result     = res;
  assign result_we  = op_valid & wr;
  assign flags_next = nx;
  assign flags      = flags_q;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [4:0]        op_code,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] mem_in,
  input logic [DATA_W-1:0] result,
  input logic              result_we,
  input logic [4:0]        flags_next,
  input logic [4:0]        flags
);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags)); // R12

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> flags == $past(flags_next)); // R12

  AST_NZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code <= 5'd21) |-> (flags_next[2] == result[DATA_W-1]) && (flags_next[1] == (result == '0))); // R11

  AST_NO_WRITE_TESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd4 || op_code == 5'd8 || op_code == 5'd20 || op_code >= 5'd22) |-> !result_we); // R1

  AST_COM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd12) |-> flags_next[0]); // R5

  AST_I_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code != 5'd24 && op_code != 5'd25) |-> flags_next[3] == flags[3]); // R10

  AST_H_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 5'd1) |-> flags_next[4] == flags[4]); // R2

  AST_INCDEC_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd18 || op_code == 5'd19) |-> flags_next[0] == flags[0]); // R8

  AST_STORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd10) |-> result == acc_in); // R4

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd9) |-> result == mem_in); // R4

  AST_UNDEF_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 5'd25) |-> !result_we && flags_next == flags); // R13

endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int CLK_NS = 4;

  localparam logic [4:0] ADD = 5'd0,  ADC = 5'd1,  SUB = 5'd2,  SBC = 5'd3,
                         CMP = 5'd4,  AND = 5'd5,  ORR = 5'd6,  XOR = 5'd7,
                         BTT = 5'd8,  LDD = 5'd9,  STO = 5'd10, NEG = 5'd11,
                         COM = 5'd12, LSR = 5'd13, ASR = 5'd14, ROR = 5'd15,
                         ROL = 5'd16, LSL = 5'd17, INC = 5'd18, DEC = 5'd19,
                         TST = 5'd20, CLR = 5'd21, SEC = 5'd22, CLC = 5'd23,
                         SEI = 5'd24, CLI = 5'd25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] mem_in = 8'h00;
  logic [7:0] result;
  logic       result_we;
  logic [4:0] flags_next;
  logic [4:0] flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .mem_in(mem_in), .result(result), .result_we(result_we),
    .flags_next(flags_next), .flags(flags)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // one operation: check comb outputs, then the loaded flag file
  task automatic exec(input logic [4:0] op, input logic [7:0] a, input logic [7:0] m,
                      input logic [7:0] exp_r, input logic exp_w, input logic [4:0] exp_f,
                      input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_in = a; mem_in = m;
    #1;
    chk(tag, "result", result, exp_r);
    chk(tag, "result_we", {7'd0, result_we}, {7'd0, exp_w});
    chk(tag, "flags_next", {3'd0, flags_next}, {3'd0, exp_f});
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    chk(tag, "flags", {3'd0, flags}, {3'd0, exp_f});
  endtask

  task automatic t_reset();
    #1;
    chk("R12", "reset flags", {3'd0, flags}, 8'h08);
    chk("R1", "we in reset", {7'd0, result_we}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_add();
    exec(CLC, 8'h00, 8'h00, 8'h00, 1'b0, 5'b01000, "R10");
    exec(ADD, 8'h08, 8'h08, 8'h10, 1'b1, 5'b11000, "R2 half");
    exec(ADD, 8'hF0, 8'h20, 8'h10, 1'b1, 5'b01001, "R2 carry");
    exec(ADC, 8'h01, 8'h01, 8'h03, 1'b1, 5'b01000, "R2 cin");
    exec(ADD, 8'h80, 8'h80, 8'h00, 1'b1, 5'b01011, "R11 zero");
  endtask

  task automatic t_sub();
    exec(SUB, 8'h05, 8'h07, 8'hFE, 1'b1, 5'b01101, "R3 borrow");
    exec(SBC, 8'h10, 8'h0F, 8'h00, 1'b1, 5'b01010, "R3 sbc");
    exec(CMP, 8'h03, 8'h04, 8'hFF, 1'b0, 5'b01101, "R3 cmp");
    exec(NEG, 8'h55, 8'h01, 8'hFF, 1'b1, 5'b01101, "R3 neg");
    exec(NEG, 8'h55, 8'h00, 8'h00, 1'b1, 5'b01010, "R3 neg0");
  endtask

  task automatic t_logic();
    exec(ADD, 8'h08, 8'h08, 8'h10, 1'b1, 5'b11000, "R2");
    exec(SEC, 8'h00, 8'h00, 8'h00, 1'b0, 5'b11001, "R10");
    exec(AND, 8'hF0, 8'h3C, 8'h30, 1'b1, 5'b11001, "R4 and");
    exec(ORR, 8'h80, 8'h01, 8'h81, 1'b1, 5'b11101, "R4 or");
    exec(XOR, 8'h5A, 8'h5A, 8'h00, 1'b1, 5'b11011, "R4 xor");
    exec(BTT, 8'h0F, 8'hF0, 8'h00, 1'b0, 5'b11011, "R4 bit");
    exec(LDD, 8'h00, 8'h80, 8'h80, 1'b1, 5'b11101, "R4 load");
    exec(STO, 8'h00, 8'h55, 8'h00, 1'b1, 5'b11011, "R4 store");
  endtask

  task automatic t_com();
    exec(COM, 8'h00, 8'hFF, 8'h00, 1'b1, 5'b11011, "R5");
    exec(CLC, 8'h00, 8'h00, 8'h00, 1'b0, 5'b11010, "R10");
    exec(COM, 8'h00, 8'h0F, 8'hF0, 1'b1, 5'b11101, "R5");
  endtask

  task automatic t_shift();
    exec(ROR, 8'h00, 8'h02, 8'h81, 1'b1, 5'b11100, "R6 ror");
    exec(LSR, 8'h00, 8'h81, 8'h40, 1'b1, 5'b11001, "R6 lsr");
    exec(ASR, 8'h00, 8'h81, 8'hC0, 1'b1, 5'b11101, "R6 asr");
    exec(ROL, 8'h00, 8'h80, 8'h01, 1'b1, 5'b11001, "R7 rol");
    exec(LSL, 8'h00, 8'h80, 8'h00, 1'b1, 5'b11011, "R7 lsl");
    exec(ROL, 8'h00, 8'h00, 8'h01, 1'b1, 5'b11000, "R7 rol");
    exec(ROR, 8'h00, 8'h01, 8'h00, 1'b1, 5'b11011, "R6 ror");
  endtask

  task automatic t_incdec();
    exec(INC, 8'h00, 8'hFF, 8'h00, 1'b1, 5'b11011, "R8 wrap up");
    exec(DEC, 8'h00, 8'h00, 8'hFF, 1'b1, 5'b11101, "R8 wrap dn");
    exec(INC, 8'h00, 8'h7F, 8'h80, 1'b1, 5'b11101, "R8");
    exec(DEC, 8'h00, 8'h01, 8'h00, 1'b1, 5'b11011, "R8");
  endtask

  task automatic t_clrtst();
    exec(CLC, 8'h00, 8'h00, 8'h00, 1'b0, 5'b11010, "R10");
    exec(TST, 8'h00, 8'h90, 8'h90, 1'b0, 5'b11100, "R9 tst");
    exec(CLR, 8'h00, 8'h55, 8'h00, 1'b1, 5'b11010, "R9 clr");
  endtask

  task automatic t_mask();
    exec(CLI, 8'h00, 8'h00, 8'h00, 1'b0, 5'b10010, "R10 cli");
    exec(SEI, 8'h00, 8'h00, 8'h00, 1'b0, 5'b11010, "R10 sei");
    exec(SEC, 8'h00, 8'h00, 8'h00, 1'b0, 5'b11011, "R10 sec");
  endtask

  task automatic t_undef();
    exec(5'd27, 8'hFF, 8'h01, 8'h00, 1'b0, 5'b11011, "R13");
    exec(5'd31, 8'h00, 8'h00, 8'h00, 1'b0, 5'b11011, "R13");
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_valid = 1'b0; op_code = CLC; acc_in = 8'h00; mem_in = 8'h00;
    @(posedge clk); #1;
    chk("R12 idle", "flags", {3'd0, flags}, 8'h1B);
    @(negedge clk);
    op_code = STO;
    #1;
    chk("R1 idle", "result_we", {7'd0, result_we}, 8'h00);
    @(posedge clk); #1;
    chk("R12 idle", "flags", {3'd0, flags}, 8'h1B);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_com();
    t_shift();
    t_incdec();
    t_clrtst();
    t_mask();
    t_undef();
    t_idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule